// File: doc/BRIEF.md
# Range Filter with Lane Compaction

This block is a streaming selection stage for a column scan. Each accepted input beat carries a fixed number of lanes. Every lane holds an unsigned key and the row offset of the row that the key came from. Each lane's key is tested against a closed interval given by two bound inputs, which yields one match bit per lane. Only the offsets of the matching lanes are passed on. They are packed into the lowest output slots and keep their lane order.

Each output beat is tagged with the write position at which its first entry belongs in the downstream offset buffer. That position then moves forward by the number of matches in the beat, so consecutive beats fill the buffer with no gaps. A running total of matches is also kept. A synchronous clear input sets the position and the total back to zero between scans. Input and output are valid/ready streams with a single registered stage between them.

Top module: `range_compact_filter`

## Requirements
- R1: A lane matches exactly when lo_bound <= key <= hi_bound, with keys and bounds compared as unsigned numbers. When lo_bound > hi_bound, no lane matches.
- R2: An output beat holds the offsets of the matching lanes in ascending lane order. Slot j occupies bits [j*OFF_W +: OFF_W] of out_offs and lane i occupies bits [i*KEY_W +: KEY_W] of in_keys. Slots at or above out_num read zero.
- R3: out_num equals the number of matching lanes in the input beat that produced the output beat.
- R4: out_wptr of a beat equals the total number of matches in all beats accepted since the last clear or reset, taken modulo 2^PTR_W. match_total increases by the match count of every accepted beat.
- R5: An accepted beat with no matching lane produces no output beat and leaves match_total and the write position unchanged.
- R6: While out_valid is high and out_ready is low, the output beat is held stable, in_ready is low, and no match is lost.
- R7: While clr is high, in_ready is low. One cycle after clr is high, match_total is zero, out_valid is low (a pending beat is discarded), and the next beat starts at write position zero.
- R8: After reset, out_valid is low, match_total is zero and in_ready is high.
- R9: A beat that is accepted at a clock edge with at least one match drives out_valid high right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| clr | input | 1 | Scan clear: zeroes the write position and the match total |
| lo_bound | input | KEY_W | Inclusive lower bound |
| hi_bound | input | KEY_W | Inclusive upper bound |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high together with in_valid |
| in_keys | input | LANES*KEY_W | Per-lane keys, lane 0 in the low bits |
| in_offs | input | LANES*OFF_W | Per-lane row offsets, lane 0 in the low bits |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts the output beat |
| out_offs | output | LANES*OFF_W | Packed matching offsets, slot 0 in the low bits |
| out_num | output | NUM_W | Number of valid slots in out_offs |
| out_wptr | output | PTR_W | Buffer write position of slot 0 |
| match_total | output | CNT_W | Matches accumulated since the last clear |

## Verification
The hardest case to reach is a long run of beats accepted back to back while the consumer stalls at random. Under those conditions the write position has to wrap past 2^PTR_W without skipping or repeating a slot. The stimulus sends more than a hundred random beats under random out_ready throttling, so that the position wraps at least once, and a scoreboard checks each beat's base position against a running model. Discarding a stalled beat on clear is reached by forcing out_ready low, sending a matching beat and then pulsing clr while that beat is still held.

// File: rtl/rcf_pkg.sv
package rcf_pkg;
    localparam int DEF_LANES = 6;
    localparam int DEF_KEY_W = 8;
    localparam int DEF_OFF_W = 16;
    localparam int DEF_PTR_W = 8;
    localparam int DEF_CNT_W = 24;

    function automatic int num_width(input int lanes);
        return $clog2(lanes + 1);
    endfunction
endpackage

// File: rtl/rcf_lane_cmp.sv
module rcf_lane_cmp #(
    parameter int LANES = 6,
    parameter int KEY_W = 8
) (
    input  logic [LANES*KEY_W-1:0] keys,
    input  logic [KEY_W-1:0]       lo,
    input  logic [KEY_W-1:0]       hi,
    output logic [LANES-1:0]       hit
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [KEY_W-1:0] k;
        assign k      = keys[g*KEY_W +: KEY_W];
        assign hit[g] = (k >= lo) && (k <= hi);
    end
endmodule

// File: rtl/rcf_compact.sv
module rcf_compact #(
    parameter int LANES = 6,
    parameter int OFF_W = 16,
    parameter int NUM_W = 3
) (
    input  logic [LANES-1:0]       hit,
    input  logic [LANES*OFF_W-1:0] offs,
    output logic [LANES*OFF_W-1:0] packed_offs,
    output logic [NUM_W-1:0]       num
);
    // pos[i] = number of hits in lanes below i (exclusive prefix sum)
    logic [NUM_W-1:0] pos [LANES+1];

    assign pos[0] = '0;
    for (genvar g = 0; g < LANES; g++) begin : g_pfx
        assign pos[g+1] = pos[g] + {{(NUM_W-1){1'b0}}, hit[g]};
    end
    assign num = pos[LANES];

    for (genvar s = 0; s < LANES; s++) begin : g_slot
        logic [LANES-1:0] sel;
        logic [OFF_W-1:0] val;
        always_comb begin
            val = '0;
            for (int i = 0; i < LANES; i++) begin
                sel[i] = hit[i] && (pos[i] == NUM_W'(s));
                if (sel[i]) val = val | offs[i*OFF_W +: OFF_W];
            end
            AST_SLOT_ONE_SRC: assert ($onehot0(sel)); // R2
        end
        assign packed_offs[s*OFF_W +: OFF_W] = val;
    end

    always_comb begin
        AST_COUNT_MATCH: assert (num == NUM_W'($countones(hit))); // R3
    end
endmodule

// File: rtl/range_compact_filter.sv
module range_compact_filter
    import rcf_pkg::*;
#(
    parameter int LANES = DEF_LANES,
    parameter int KEY_W = DEF_KEY_W,
    parameter int OFF_W = DEF_OFF_W,
    parameter int PTR_W = DEF_PTR_W,
    parameter int CNT_W = DEF_CNT_W,
    localparam int NUM_W = num_width(LANES)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   clr,
    input  logic [KEY_W-1:0]       lo_bound,
    input  logic [KEY_W-1:0]       hi_bound,
    input  logic                   in_valid,
    output logic                   in_ready,
    input  logic [LANES*KEY_W-1:0] in_keys,
    input  logic [LANES*OFF_W-1:0] in_offs,
    output logic                   out_valid,
    input  logic                   out_ready,
    output logic [LANES*OFF_W-1:0] out_offs,
    output logic [NUM_W-1:0]       out_num,
    output logic [PTR_W-1:0]       out_wptr,
    output logic [CNT_W-1:0]       match_total
);
    typedef struct packed {
        logic                   vld;
        logic [LANES*OFF_W-1:0] offs;
        logic [NUM_W-1:0]       num;
        logic [PTR_W-1:0]       base;
        logic [PTR_W-1:0]       wptr;
        logic [CNT_W-1:0]       total;
    } state_t;

    state_t st_d, st_q;

    logic [LANES-1:0]       hit;
    logic [LANES*OFF_W-1:0] packed_offs;
    logic [NUM_W-1:0]       hit_num;
    logic                   accept;

    rcf_lane_cmp #(.LANES(LANES), .KEY_W(KEY_W)) u_cmp (
        .keys (in_keys),
        .lo   (lo_bound),
        .hi   (hi_bound),
        .hit  (hit)
    );

    rcf_compact #(.LANES(LANES), .OFF_W(OFF_W), .NUM_W(NUM_W)) u_pack (
        .hit         (hit),
        .offs        (in_offs),
        .packed_offs (packed_offs),
        .num         (hit_num)
    );

    assign in_ready = !clr && (!st_q.vld || out_ready);
    assign accept   = in_valid && in_ready;

    always_comb begin
        st_d = st_q;
        if (st_q.vld && out_ready) st_d.vld = 1'b0;
        if (accept) begin
            if (hit_num != '0) begin
                st_d.vld  = 1'b1;
                st_d.offs = packed_offs;
                st_d.num  = hit_num;
                st_d.base = st_q.wptr;
            end
            st_d.wptr  = st_q.wptr + PTR_W'(hit_num);
            st_d.total = st_q.total + CNT_W'(hit_num);
        end
        if (clr) begin
            st_d.vld   = 1'b0;
            st_d.wptr  = '0;
            st_d.total = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign out_valid   = st_q.vld;
    assign out_offs    = st_q.offs;
    assign out_num     = st_q.num;
    assign out_wptr    = st_q.base;
    assign match_total = st_q.total;

    AST_NO_EMPTY_BEAT: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_num != '0) && (out_num <= NUM_W'(LANES))); // R5
    AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |-> !in_ready); // R6
    AST_HOLD_BEAT: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready && !clr) |=>
            out_valid && $stable(out_offs) && $stable(out_num) && $stable(out_wptr)); // R6
    AST_TOTAL_STEP: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=>
            match_total == $past(match_total) + (out_valid ? CNT_W'(out_num) : '0)); // R4
    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
        clr |=> (match_total == '0) && !out_valid); // R7
    AST_CLEAR_NO_TAKE: assert property (@(posedge clk) disable iff (rst)
        clr |-> !in_ready); // R7
endmodule

// File: tb/range_compact_filter_tb.sv
module range_compact_filter_tb;
    localparam int LANES = 6;
    localparam int KEY_W = 8;
    localparam int OFF_W = 16;
    localparam int PTR_W = 8;
    localparam int CNT_W = 24;
    localparam int NUM_W = 3;

    logic clk = 0, rst = 1, clr = 0;
    logic [KEY_W-1:0] lo_bound = '0, hi_bound = '0;
    logic in_valid = 0, in_ready;
    logic [LANES*KEY_W-1:0] in_keys = '0;
    logic [LANES*OFF_W-1:0] in_offs = '0;
    logic out_valid, out_ready = 1;
    logic [LANES*OFF_W-1:0] out_offs;
    logic [NUM_W-1:0] out_num;
    logic [PTR_W-1:0] out_wptr;
    logic [CNT_W-1:0] match_total;

    range_compact_filter #(.LANES(LANES), .KEY_W(KEY_W), .OFF_W(OFF_W),
        .PTR_W(PTR_W), .CNT_W(CNT_W)) u_dut (.*);

    always #5 clk = ~clk;

    typedef struct {
        logic [LANES*OFF_W-1:0] offs;
        int num;
        int base;
    } exp_t;
    exp_t sb[$];

    int errs = 0, checks = 0;
    int mdl_ptr = 0, mdl_total = 0, row = 0;
    int rdy_mode = 0; // 0: always ready, 1: random, 2: stalled

    task automatic chk(input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        #2;
        case (rdy_mode)
            0: out_ready = 1'b1;
            1: out_ready = ($urandom % 3) != 0;
            default: out_ready = 1'b0;
        endcase
    end

    // monitor: compares each handed-over beat against the scoreboard
    always @(negedge clk) begin
        if (!rst && out_valid && out_ready) begin
            if (sb.size() == 0) begin
                chk("R5", "unexpected output beat", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk("R3", "out_num", out_num, e.num);
                chk("R2", "out_offs", out_offs, e.offs);
                chk("R4", "out_wptr", out_wptr, e.base);
            end
        end
    end

    function automatic logic [LANES*KEY_W-1:0] keys6(input logic [7:0] k0, k1, k2, k3, k4, k5);
        return {k5, k4, k3, k2, k1, k0};
    endfunction

    function automatic logic [LANES*OFF_W-1:0] next_offs();
        logic [LANES*OFF_W-1:0] o;
        for (int i = 0; i < LANES; i++) o[i*OFF_W +: OFF_W] = OFF_W'(row + i);
        row += LANES;
        return o;
    endfunction

    // driver: presents one beat, waits for acceptance, records the expectation
    task automatic send(input logic [LANES*KEY_W-1:0] k, input logic [LANES*OFF_W-1:0] o,
                        input bit track);
        exp_t e;
        int n;
        @(negedge clk);
        in_valid = 1; in_keys = k; in_offs = o;
        #1;
        while (!in_ready) begin @(negedge clk); #1; end
        @(posedge clk);
        e.offs = '0; n = 0;
        for (int i = 0; i < LANES; i++) begin
            if (k[i*KEY_W +: KEY_W] >= lo_bound && k[i*KEY_W +: KEY_W] <= hi_bound) begin
                e.offs[n*OFF_W +: OFF_W] = o[i*OFF_W +: OFF_W];
                n++;
            end
        end
        e.num = n; e.base = mdl_ptr;
        if (track) begin
            if (n > 0) sb.push_back(e);
            mdl_ptr = (mdl_ptr + n) % (1 << PTR_W);
            mdl_total += n;
        end
        #1 in_valid = 0;
    endtask

    task automatic drain();
        int guard = 0;
        while ((sb.size() != 0 || out_valid) && guard < 1000) begin
            @(negedge clk); guard++;
        end
        @(negedge clk);
        chk("R6", "scoreboard drained", sb.size(), 0);
        chk("R4", "match_total", match_total, mdl_total);
    endtask

    initial begin
        #(200000 * 10);
        errs++; checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [LANES*OFF_W-1:0] held;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk("R8", "out_valid after reset", out_valid, 0);
        chk("R8", "match_total after reset", match_total, 0);
        chk("R8", "in_ready after reset", in_ready, 1);

        // worked example: range O..U, expect offsets 1,3,4
        lo_bound = "O"; hi_bound = "U"; row = 0;
        send(keys6("J", "O", "Y", "S", "U", "X"), next_offs(), 1);
        @(negedge clk);
        chk("R9", "out_valid one cycle after accept", out_valid, 1);
        chk("R3", "example count", out_num, 3);
        drain();

        // R1 boundaries: equal to each bound matches, one past does not
        lo_bound = 8'h20; hi_bound = 8'h40;
        send(keys6(8'h1F, 8'h20, 8'h40, 8'h41, 8'h30, 8'hFF), next_offs(), 1);
        drain();

        // R5 empty mask
        send(keys6(8'h00, 8'h10, 8'h41, 8'h80, 8'h1F, 8'hFF), next_offs(), 1);
        repeat (2) @(negedge clk);
        chk("R5", "no beat for empty mask", out_valid, 0);
        chk("R5", "total unchanged", match_total, mdl_total);

        // all lanes match
        lo_bound = 8'h00; hi_bound = 8'hFF;
        send(keys6(8'h00, 8'h01, 8'h7F, 8'h80, 8'hFE, 8'hFF), next_offs(), 1);
        drain();

        // R1 inverted bounds: nothing matches
        lo_bound = 8'h80; hi_bound = 8'h10;
        send(keys6(8'h80, 8'h10, 8'h50, 8'h00, 8'hFF, 8'h08), next_offs(), 1);
        repeat (2) @(negedge clk);
        chk("R1", "inverted range no beat", out_valid, 0);

        // R6 stall holds the beat
        lo_bound = 8'h00; hi_bound = 8'h7F;
        rdy_mode = 2;
        @(negedge clk);
        send(keys6(8'h90, 8'h05, 8'hA0, 8'h06, 8'h07, 8'hF0), next_offs(), 1);
        @(negedge clk);
        held = out_offs;
        repeat (3) @(negedge clk);
        chk("R6", "beat held valid", out_valid, 1);
        chk("R6", "beat held stable", out_offs, held);
        chk("R6", "in_ready low under stall", in_ready, 0);
        rdy_mode = 0;
        drain();

        // random run under throttling, long enough to wrap the write position
        lo_bound = 8'h40; hi_bound = 8'hB0;
        rdy_mode = 1;
        for (int b = 0; b < 130; b++) begin
            logic [LANES*KEY_W-1:0] rk;
            for (int i = 0; i < LANES; i++) rk[i*KEY_W +: KEY_W] = KEY_W'($urandom);
            send(rk, next_offs(), 1);
        end
        rdy_mode = 0;
        drain();
        chk("R4", "write position wrapped", (mdl_total >= (1 << PTR_W)), 1);

        // R7 clear between scans
        @(negedge clk);
        clr = 1; #1;
        chk("R7", "in_ready low during clear", in_ready, 0);
        @(negedge clk);
        clr = 0;
        chk("R7", "total zero after clear", match_total, 0);
        mdl_ptr = 0; mdl_total = 0;
        send(keys6(8'h50, 8'h00, 8'h60, 8'h00, 8'h00, 8'h70), next_offs(), 1);
        drain();

        // R7 clear discards a stalled beat
        rdy_mode = 2;
        @(negedge clk);
        send(keys6(8'h50, 8'h51, 8'h00, 8'h00, 8'h00, 8'h00), next_offs(), 0);
        @(negedge clk);
        chk("R6", "stalled beat present", out_valid, 1);
        clr = 1;
        @(negedge clk);
        clr = 0;
        chk("R7", "pending beat discarded", out_valid, 0);
        chk("R7", "total zero after second clear", match_total, 0);
        rdy_mode = 0;
        mdl_ptr = 0; mdl_total = 0;
        send(keys6(8'h00, 8'h44, 8'h00, 8'h00, 8'h00, 8'h00), next_offs(), 1);
        drain();

        finish_run();
    end
endmodule